// File: doc/BRIEF.md
# Serial Lane Wrapper Register Block

This block is the small control and status register set that sits between a 32-bit read/write bus and the analog lane of a high-speed serial link. Software drives the lane through two command registers, one steering the receive side (power-down, sleep, calibration, clock-recovery reset, data enable, manual override) and one that starts hardware initialisation of the transmit and receive lanes. The lane hardware answers with completion strobes, a level that says the transmit path is powered, and a link event pulse.

Some command bits are set by software and cleared by hardware. The calibration request drops when the lane reports that calibration has finished. The transmit-init request drops when the lane reports that power-up has finished, or on the cycle after it is set if the transmit path was already powered. Software polls the bit until it reads zero. Link events are latched in an interrupt status register that software clears by writing ones. A single level interrupt output stays high while any latched bit is set.

Reads are combinational: `bus_rdata_o` shows the addressed register while `bus_rd_i` is high, and is zero at all other times. Writes take effect on the rising clock edge where `bus_wr_i` is high.

Top module: `lane_wrap_regs`

## Requirements
- R1: After reset, every mapped register reads zero, both command outputs are zero and `irq_o` is low.
- R2: The receive-control register at offset 0x801C stores only the writable bits 31, 10, 9, 8, 7, 6, 5, 4 and 0 (mask 0x800007F1). All other bits read as zero. The stored value drives `rx_ctrl_o`.
- R3: Receive-control bit 8 (calibration request) clears on the edge where `cal_done_i` is high while the bit is set. No other bit of that register changes.
- R4: A write to receive-control on the same edge as `cal_done_i` loads the written value, so the write wins. `cal_done_i` has no effect while bit 8 is clear.
- R5: The hardware-init register at offset 0x8020 keeps bit 0 (transmit-init) and bit 2 (receive-init), and all other bits read as zero. Bit 0 clears on the edge where `tx_done_i` is high, and bit 2 is unaffected by it.
- R6: If bit 0 of hardware-init is set while `tx_pwr_up_i` is high, it clears on the next clock edge.
- R7: The lane status register at offset 0x8044 reads `tx_pwr_up_i` in bit 0 and zero elsewhere. Writes to it have no effect.
- R8: The interrupt status register at offset 0x8050 latches `link_evt_i` in bit 6. Writing a one to bit 6 clears it, and writing zero leaves it set. `irq_o` is high exactly while the latched bit is set.
- R9: When `link_evt_i` and a write-one-to-clear of bit 6 happen on the same edge, the bit stays set.
- R10: Reads of any unmapped offset return zero, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 16 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when not reading |
| rx_ctrl_o | output | 32 | Receive-control register contents to the lane |
| hw_ctrl_o | output | 32 | Hardware-init register contents to the lane |
| tx_pwr_up_i | input | 1 | Transmit path powered (level) |
| tx_done_i | input | 1 | Transmit power-up finished (strobe) |
| cal_done_i | input | 1 | Receive calibration finished (strobe) |
| link_evt_i | input | 1 | Link status event (strobe) |
| irq_o | output | 1 | Level interrupt |

## Verification
The self-clearing commands are driven in four ways:
- a completion strobe while the bit is set, which must clear it;
- a strobe while the bit is clear, which must do nothing;
- a strobe on the same edge as a write, where the write must win;
- a transmit-init write while the lane already reports power.

These four cases separate a clear that is tied to the strobe from a clear that is tied to the held bit or to the write.

The interrupt bit is cleared three ways:
- with a one, which must clear it;
- with a zero, which must not;
- with a one on the same edge as a new event, where the event must win.

Writing all ones to every register, including the status register and unmapped offsets, shows which bits are writable and which are reserved.

// File: rtl/lw_regs_pkg.sv
package lw_regs_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 16;
    localparam int NUM_REGS = 4;

    // register index order used by the decoder and read mux
    localparam int IDX_RX  = 0;
    localparam int IDX_HW  = 1;
    localparam int IDX_ST  = 2;
    localparam int IDX_IRQ = 3;

    localparam logic [ADDR_W-1:0] OFF_RX  = 16'h801C;
    localparam logic [ADDR_W-1:0] OFF_HW  = 16'h8020;
    localparam logic [ADDR_W-1:0] OFF_ST  = 16'h8044;
    localparam logic [ADDR_W-1:0] OFF_IRQ = 16'h8050;

    localparam int RX_CAL_BIT   = 8;
    localparam int HW_TX_BIT    = 0;
    localparam int HW_RX_BIT    = 2;
    localparam int ST_TXUP_BIT  = 0;
    localparam int IRQ_LINK_BIT = 6;

    localparam logic [DATA_W-1:0] RX_WMASK = 32'h8000_07F1;
    localparam logic [DATA_W-1:0] HW_WMASK =
        (DATA_W'(1) << HW_TX_BIT) | (DATA_W'(1) << HW_RX_BIT);

    typedef struct packed {
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] hw;
    } ctrl_regs_t;

    typedef struct packed {
        logic link;
    } evt_regs_t;

    function automatic logic [ADDR_W-1:0] reg_offset(input int idx);
        case (idx)
            IDX_RX:  return OFF_RX;
            IDX_HW:  return OFF_HW;
            IDX_ST:  return OFF_ST;
            default: return OFF_IRQ;
        endcase
    endfunction
endpackage

// File: rtl/lw_addr_decode.sv
module lw_addr_decode
    import lw_regs_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [NUM_REGS-1:0] hit_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit_o[g] = (addr_i == reg_offset(g));
    end
endmodule

// File: rtl/lw_ctrl_regs.sv
module lw_ctrl_regs
    import lw_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rx_i,
    input  logic              wr_hw_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cal_done_i,
    input  logic              tx_done_i,
    input  logic              tx_pwr_up_i,
    output logic [DATA_W-1:0] rx_ctrl_o,
    output logic [DATA_W-1:0] hw_ctrl_o
);
    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // completion strobe drops the calibration request it answers
        if (regs_q.rx[RX_CAL_BIT] && cal_done_i) begin
            regs_d.rx[RX_CAL_BIT] = 1'b0;
        end
        // transmit init finishes on a done strobe or when already powered
        if (regs_q.hw[HW_TX_BIT] && (tx_done_i || tx_pwr_up_i)) begin
            regs_d.hw[HW_TX_BIT] = 1'b0;
        end
        // a software write on the same edge takes precedence
        if (wr_rx_i) begin
            regs_d.rx = wdata_i & RX_WMASK;
        end
        if (wr_hw_i) begin
            regs_d.hw = wdata_i & HW_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rx_ctrl_o = regs_q.rx;
    assign hw_ctrl_o = regs_q.hw;

    // R3
    cal_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ctrl_o[RX_CAL_BIT] && cal_done_i && !wr_rx_i) |=> !rx_ctrl_o[RX_CAL_BIT]);

    // R6
    tx_powered_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ctrl_o[HW_TX_BIT] && tx_pwr_up_i && !wr_hw_i) |=> !hw_ctrl_o[HW_TX_BIT]);

    // R2
    rx_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ctrl_o & ~RX_WMASK) == '0);

    // R5
    hw_rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hw_i) |=> $stable(hw_ctrl_o[HW_RX_BIT]));
endmodule

// File: rtl/lw_event_regs.sv
module lw_event_regs
    import lw_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w1c_i,
    input  logic              clr_link_i,
    input  logic              link_evt_i,
    output logic [DATA_W-1:0] status_o
);
    evt_regs_t evt_d, evt_q;

    always_comb begin
        evt_d = evt_q;
        if (w1c_i && clr_link_i) begin
            evt_d.link = 1'b0;
        end
        // hardware set is applied last so it wins over a same-edge clear
        if (link_evt_i) begin
            evt_d.link = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    always_comb begin
        status_o = '0;
        status_o[IRQ_LINK_BIT] = evt_q.link;
    end

    // R9
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt_i |=> status_o[IRQ_LINK_BIT]);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i && clr_link_i && !link_evt_i) |=> !status_o[IRQ_LINK_BIT]);
endmodule

// File: rtl/lane_wrap_regs.sv
module lane_wrap_regs
    import lw_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [DATA_W-1:0] rx_ctrl_o,
    output logic [DATA_W-1:0] hw_ctrl_o,
    input  logic              tx_pwr_up_i,
    input  logic              tx_done_i,
    input  logic              cal_done_i,
    input  logic              link_evt_i,
    output logic              irq_o
);
    logic [NUM_REGS-1:0] hit;
    logic [DATA_W-1:0]   irq_status;
    logic [DATA_W-1:0]   lane_status;
    logic [DATA_W-1:0]   reg_view [NUM_REGS];

    lw_addr_decode u_dec (
        .addr_i (bus_addr_i),
        .hit_o  (hit)
    );

    lw_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_rx_i     (bus_wr_i && hit[IDX_RX]),
        .wr_hw_i     (bus_wr_i && hit[IDX_HW]),
        .wdata_i     (bus_wdata_i),
        .cal_done_i  (cal_done_i),
        .tx_done_i   (tx_done_i),
        .tx_pwr_up_i (tx_pwr_up_i),
        .rx_ctrl_o   (rx_ctrl_o),
        .hw_ctrl_o   (hw_ctrl_o)
    );

    lw_event_regs u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .w1c_i      (bus_wr_i && hit[IDX_IRQ]),
        .clr_link_i (bus_wdata_i[IRQ_LINK_BIT]),
        .link_evt_i (link_evt_i),
        .status_o   (irq_status)
    );

    always_comb begin
        lane_status = '0;
        lane_status[ST_TXUP_BIT] = tx_pwr_up_i;
    end

    assign reg_view[IDX_RX]  = rx_ctrl_o;
    assign reg_view[IDX_HW]  = hw_ctrl_o;
    assign reg_view[IDX_ST]  = lane_status;
    assign reg_view[IDX_IRQ] = irq_status;

    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (bus_rd_i && hit[i]) begin
                bus_rdata_o = bus_rdata_o | reg_view[i];
            end
        end
    end

    assign irq_o = |irq_status;

    // R10
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && (hit == '0)) |-> (bus_rdata_o == '0));

    // R8
    irq_follows_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_evt_i |=> irq_o);
endmodule

// File: tb/lane_wrap_regs_test.sv
module lane_wrap_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] rx_ctrl;
    logic [31:0] hw_ctrl;
    logic        tx_pwr_up = 1'b0;
    logic        tx_done = 1'b0;
    logic        cal_done = 1'b0;
    logic        link_evt = 1'b0;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    lane_wrap_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .rx_ctrl_o   (rx_ctrl),
        .hw_ctrl_o   (hw_ctrl),
        .tx_pwr_up_i (tx_pwr_up),
        .tx_done_i   (tx_done),
        .cal_done_i  (cal_done),
        .link_evt_i  (link_evt),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        bus_read(16'h801C, v); check("R1 rx reg", v, 0);
        bus_read(16'h8020, v); check("R1 hw reg", v, 0);
        bus_read(16'h8050, v); check("R1 irq reg", v, 0);
        check("R1 outputs", {rx_ctrl | hw_ctrl, 31'b0} >> 31 | {31'b0, irq}, 0);
    endtask

    task automatic test_rx_mask();
        logic [31:0] v;
        bus_write(16'h801C, 32'hFFFF_FFFF);
        bus_read(16'h801C, v); check("R2 writable mask", v, 32'h8000_07F1);
        check("R2 rx_ctrl_o", rx_ctrl, 32'h8000_07F1);
        bus_write(16'h801C, 32'h0000_0000);
        bus_read(16'h801C, v); check("R2 clear", v, 0);
    endtask

    task automatic test_cal_clear();
        logic [31:0] v;
        bus_write(16'h801C, 32'h8000_0101);
        bus_read(16'h801C, v); check("R3 cal set", v, 32'h8000_0101);
        @(negedge clk); cal_done = 1'b1;
        @(negedge clk); cal_done = 1'b0;
        bus_read(16'h801C, v); check("R3 cal self-clear keeps others", v, 32'h8000_0001);
    endtask

    task automatic test_cal_corner();
        logic [31:0] v;
        @(negedge clk); cal_done = 1'b1;
        @(negedge clk); cal_done = 1'b0;
        bus_read(16'h801C, v); check("R4 done with cal clear", v, 32'h8000_0001);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h801C; bus_wdata = 32'h0000_0110; cal_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cal_done = 1'b0;
        bus_read(16'h801C, v); check("R4 write wins over done", v, 32'h0000_0110);
    endtask

    task automatic test_hw_init();
        logic [31:0] v;
        bus_write(16'h8020, 32'hFFFF_FFFF);
        bus_read(16'h8020, v); check("R5 hw mask", v, 32'h5);
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        bus_read(16'h8020, v); check("R5 tx clears, rx stays", v, 32'h4);
        check("R5 hw_ctrl_o", hw_ctrl, 32'h4);
    endtask

    task automatic test_tx_powered();
        logic [31:0] v;
        @(negedge clk); tx_pwr_up = 1'b1;
        bus_write(16'h8020, 32'h1);
        bus_read(16'h8020, v); check("R6 set visible one cycle", v, 32'h1);
        @(negedge clk);
        bus_read(16'h8020, v); check("R6 cleared next cycle", v, 32'h0);
    endtask

    task automatic test_status();
        logic [31:0] v;
        bus_read(16'h8044, v); check("R7 powered", v, 32'h1);
        bus_write(16'h8044, 32'hFFFF_FFFF);
        @(negedge clk); tx_pwr_up = 1'b0;
        #1;
        bus_read(16'h8044, v); check("R7 unpowered after write", v, 32'h0);
    endtask

    task automatic test_link_w1c();
        logic [31:0] v;
        @(negedge clk); link_evt = 1'b1;
        @(negedge clk); link_evt = 1'b0;
        bus_read(16'h8050, v); check("R8 latched", v, 32'h40);
        check("R8 irq high", {31'b0, irq}, 1);
        bus_write(16'h8050, 32'hFFFF_FFBF);
        bus_read(16'h8050, v); check("R8 zero write keeps", v, 32'h40);
        bus_write(16'h8050, 32'h40);
        bus_read(16'h8050, v); check("R8 w1c clears", v, 32'h0);
        check("R8 irq low", {31'b0, irq}, 0);
    endtask

    task automatic test_set_wins();
        logic [31:0] v;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'h8050; bus_wdata = 32'h40; link_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; link_evt = 1'b0;
        bus_read(16'h8050, v); check("R9 hw set wins", v, 32'h40);
        check("R9 irq", {31'b0, irq}, 1);
    endtask

    task automatic test_unmapped();
        logic [31:0] v;
        bus_read(16'h8000, v); check("R10 read 0x8000", v, 0);
        bus_read(16'h8024, v); check("R10 read 0x8024", v, 0);
        bus_write(16'h8024, 32'hFFFF_FFFF);
        bus_write(16'h801D, 32'hFFFF_FFFF);
        bus_read(16'h801C, v); check("R10 rx untouched", v, 32'h0000_0110);
        bus_read(16'h8020, v); check("R10 hw untouched", v, 32'h0);
        bus_read(16'h8050, v); check("R10 irq untouched", v, 32'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_rx_mask();
        test_cal_clear();
        test_cal_corner();
        test_hw_init();
        test_tx_powered();
        test_status();
        test_link_w1c();
        test_set_wins();
        test_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule